// File: doc/BRIEF.md
# Banked Register File Operand Arbiter

This block models the operand delivery path of a wide SIMD core. The register file is split into single-ported banks, and each bank entry holds one whole warp register. A set of operand collectors sits in front of it, each holding one issued instruction with up to three register sources. Every cycle each busy collector asks for one missing source. A per-bank arbiter grants at most one access per bank, and a writeback to a bank takes that bank's port for the cycle. Contention therefore comes from two limits at once: a bank serves one access per cycle, and a collector takes one operand per cycle.

An issue stage allocates an instruction into a free collector by giving its warp, its source count and its register numbers. A collector whose sources have all arrived raises its ready bit. A round-robin selector among the ready collectors then offers one of them on a single dispatch port, with a valid/ready handshake. Bank count, warp count, registers per warp, collector count and data width are parameters.

Top module: `operand_bank_arbiter`

## Requirements
- R1: Register (w, r) lives in bank (w + r) mod NUM_BANKS. A writeback stores a value for each (warp, register) pair, and a later read of that pair returns the value last written to it.
- R2: A bank serves at most one read per cycle. Two collectors that ask for the same bank in the same cycle are served in successive cycles. Collectors that ask for different banks are served in the same cycle.
- R3: A collector receives at most one operand per cycle. With no contention, an instruction with k sources (k = 1..3) allocated in cycle 0 shows its ready bit in cycle k+1 and not in cycle k.
- R4: A writeback has priority over reads in its bank. Each writeback cycle to that bank delays a waiting read by one cycle.
- R5: A read granted in the cycle after a writeback to the same register returns the newly written value.
- R6: Source slot k of disp_src_o occupies bits [k*DATA_W +: DATA_W] and carries the k-th listed register. Slots at or above the source count read zero. disp_warp_o carries the allocated warp. Dispatch is offered only for a collector whose sources are all present.
- R7: Among ready collectors, dispatch starts searching at the collector after the one dispatched last and wraps around.
- R8: An instruction with zero sources is ready in the cycle after its allocation.
- R9: An allocation aimed at a busy collector is ignored, and the instruction already held there is dispatched unchanged.
- R10: After reset every collector is free and nothing is offered. An offer is held while disp_ready_i is low. The collector is free in the cycle after the handshake.
- R11: Each bank grants through a rotating pointer. Two collectors that keep asking for one bank alternate, so neither finishes three sources before the other has received at least two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocate an instruction this cycle |
| alloc_cu_i | input | CU_W | Target collector |
| alloc_warp_i | input | WARP_W | Warp of the instruction |
| alloc_nsrc_i | input | 2 | Number of register sources, 0..3 |
| alloc_regs_i | input | 3*REG_W | Source registers, source k at [k*REG_W +: REG_W] |
| wb_valid_i | input | 1 | Writeback this cycle |
| wb_warp_i | input | WARP_W | Writeback warp |
| wb_reg_i | input | REG_W | Writeback register |
| wb_data_i | input | DATA_W | Writeback value |
| cu_free_o | output | NUM_CU | Collector is free for allocation |
| cu_ready_o | output | NUM_CU | Collector holds all of its sources |
| disp_valid_o | output | 1 | Dispatch offer |
| disp_ready_i | input | 1 | Execution port accepts the offer |
| disp_cu_o | output | CU_W | Collector being offered |
| disp_warp_o | output | WARP_W | Warp of the offered instruction |
| disp_src_o | output | 3*DATA_W | Source values of the offered instruction |

## Verification
The latency of each result is counted from the cycle in which the allocation is presented. A read granted in cycle t reaches its collector at the edge that ends t, so with no contention ready appears in cycle k+1. Each bank conflict, writeback or alternating grant adds exactly one cycle. A writeback commits at the end of its cycle and is visible to a read one cycle later. The bench drives and samples on the falling edge. It checks each ready bit in the cycle just before it is due and again in the cycle it is due, then drains the collectors to compare warp and data.

// File: rtl/oparb_pkg.sv
package oparb_pkg;
  localparam int unsigned MAX_SRC = 3;

  function automatic int unsigned bank_of(input int unsigned warp, input int unsigned rnum,
                                          input int unsigned nbanks);
    return (warp + rnum) % nbanks;
  endfunction

  function automatic int unsigned row_of(input int unsigned warp, input int unsigned rnum,
                                         input int unsigned nbanks, input int unsigned nregs);
    return warp * (nregs / nbanks) + rnum / nbanks;
  endfunction
endpackage

// File: rtl/oparb_rr.sv
module oparb_rr #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] cand;

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    cand    = '0;
    for (int unsigned i = 0; i < N; i++) begin
      cand = IW'((32'(ptr_q) + i) % N);
      if (!valid_o && req_i[cand]) begin
        valid_o = 1'b1;
        idx_o   = cand;
      end
    end
    gnt_o = valid_o ? (N'(1) << idx_o) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i && valid_o) ptr_q <= (32'(idx_o) == N - 1) ? '0 : idx_o + IW'(1);
  end
endmodule

// File: rtl/oparb_bank.sv
module oparb_bank #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/oparb_collector.sv
module oparb_collector
  import oparb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 32,
  parameter int unsigned NUM_REGS  = 64,
  parameter int unsigned WARP_W    = 5,
  parameter int unsigned REG_W     = 6,
  parameter int unsigned BANK_W    = 5,
  parameter int unsigned ROW_W     = 6,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           alloc_i,
  input  logic [WARP_W-1:0]              warp_i,
  input  logic [1:0]                     nsrc_i,
  input  logic [MAX_SRC-1:0][REG_W-1:0]  regs_i,
  input  logic                           gnt_i,
  input  logic [DATA_W-1:0]              gnt_data_i,
  input  logic                           release_i,
  output logic                           free_o,
  output logic                           ready_o,
  output logic                           req_o,
  output logic [BANK_W-1:0]              req_bank_o,
  output logic [ROW_W-1:0]               req_row_o,
  output logic [WARP_W-1:0]              warp_o,
  output logic [MAX_SRC*DATA_W-1:0]      src_o
);
  logic                           valid_q;
  logic [WARP_W-1:0]              warp_q;
  logic [MAX_SRC-1:0][REG_W-1:0]  regs_q;
  logic [MAX_SRC-1:0]             have_q;
  logic [MAX_SRC-1:0][DATA_W-1:0] data_q;
  logic [1:0]                     pick;
  logic [REG_W-1:0]               cur_reg;

  always_comb begin
    if (!have_q[0])      pick = 2'd0;
    else if (!have_q[1]) pick = 2'd1;
    else                 pick = 2'd2;
  end

  assign cur_reg    = regs_q[pick];
  assign req_o      = valid_q && !(&have_q);
  assign req_bank_o = BANK_W'(bank_of(32'(warp_q), 32'(cur_reg), NUM_BANKS));
  assign req_row_o  = ROW_W'(row_of(32'(warp_q), 32'(cur_reg), NUM_BANKS, NUM_REGS));
  assign ready_o    = valid_q && (&have_q);
  assign free_o     = !valid_q;
  assign warp_o     = warp_q;
  assign src_o      = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      warp_q  <= '0;
      regs_q  <= '0;
      have_q  <= '0;
      data_q  <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      warp_q  <= warp_i;
      regs_q  <= regs_i;
      data_q  <= '0;
      for (int unsigned k = 0; k < MAX_SRC; k++) have_q[k] <= (k >= 32'(nsrc_i));
    end else begin
      if (gnt_i) begin
        have_q[pick] <= 1'b1;
        data_q[pick] <= gnt_data_i;
      end
      if (release_i) valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/operand_bank_arbiter.sv
module operand_bank_arbiter
  import oparb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 32,
  parameter int unsigned NUM_WARPS = 32,
  parameter int unsigned NUM_REGS  = 64,
  parameter int unsigned NUM_CU    = 8,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS),
  localparam int unsigned WARP_W = $clog2(NUM_WARPS),
  localparam int unsigned REG_W  = $clog2(NUM_REGS),
  localparam int unsigned CU_W   = (NUM_CU > 1) ? $clog2(NUM_CU) : 1,
  localparam int unsigned ROWS   = NUM_WARPS * NUM_REGS / NUM_BANKS,
  localparam int unsigned ROW_W  = $clog2(ROWS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        alloc_valid_i,
  input  logic [CU_W-1:0]             alloc_cu_i,
  input  logic [WARP_W-1:0]           alloc_warp_i,
  input  logic [1:0]                  alloc_nsrc_i,
  input  logic [MAX_SRC*REG_W-1:0]    alloc_regs_i,
  input  logic                        wb_valid_i,
  input  logic [WARP_W-1:0]           wb_warp_i,
  input  logic [REG_W-1:0]            wb_reg_i,
  input  logic [DATA_W-1:0]           wb_data_i,
  output logic [NUM_CU-1:0]           cu_free_o,
  output logic [NUM_CU-1:0]           cu_ready_o,
  output logic                        disp_valid_o,
  input  logic                        disp_ready_i,
  output logic [CU_W-1:0]             disp_cu_o,
  output logic [WARP_W-1:0]           disp_warp_o,
  output logic [MAX_SRC*DATA_W-1:0]   disp_src_o
);
  logic [NUM_CU-1:0]                       cu_req, cu_gnt, cu_alloc, cu_release, disp_gnt;
  logic [NUM_CU-1:0][BANK_W-1:0]           cu_bank;
  logic [NUM_CU-1:0][ROW_W-1:0]            cu_row;
  logic [NUM_CU-1:0][WARP_W-1:0]           cu_warp;
  logic [NUM_CU-1:0][MAX_SRC*DATA_W-1:0]   cu_src;
  logic [NUM_CU-1:0][DATA_W-1:0]           cu_gdata;
  logic [NUM_BANKS-1:0][NUM_CU-1:0]        bank_gnt;
  logic [NUM_BANKS-1:0][DATA_W-1:0]        bank_rdata;
  logic [NUM_BANKS-1:0]                    bank_wr;
  logic [BANK_W-1:0]                       wb_bank;
  logic [ROW_W-1:0]                        wb_row;

  assign wb_bank = BANK_W'(bank_of(32'(wb_warp_i), 32'(wb_reg_i), NUM_BANKS));
  assign wb_row  = ROW_W'(row_of(32'(wb_warp_i), 32'(wb_reg_i), NUM_BANKS, NUM_REGS));

  for (genvar c = 0; c < NUM_CU; c++) begin : g_cu
    assign cu_alloc[c]   = alloc_valid_i && (alloc_cu_i == CU_W'(c)) && cu_free_o[c];
    assign cu_release[c] = disp_gnt[c] && disp_ready_i;

    oparb_collector #(
      .NUM_BANKS(NUM_BANKS), .NUM_REGS(NUM_REGS), .WARP_W(WARP_W), .REG_W(REG_W),
      .BANK_W(BANK_W), .ROW_W(ROW_W), .DATA_W(DATA_W)
    ) i_cu (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (cu_alloc[c]),
      .warp_i     (alloc_warp_i),
      .nsrc_i     (alloc_nsrc_i),
      .regs_i     (alloc_regs_i),
      .gnt_i      (cu_gnt[c]),
      .gnt_data_i (cu_gdata[c]),
      .release_i  (cu_release[c]),
      .free_o     (cu_free_o[c]),
      .ready_o    (cu_ready_o[c]),
      .req_o      (cu_req[c]),
      .req_bank_o (cu_bank[c]),
      .req_row_o  (cu_row[c]),
      .warp_o     (cu_warp[c]),
      .src_o      (cu_src[c])
    );
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [NUM_CU-1:0] breq;
    logic [CU_W-1:0]   bidx;
    logic              bvalid;

    assign bank_wr[b] = wb_valid_i && (wb_bank == BANK_W'(b));

    always_comb begin
      for (int unsigned c = 0; c < NUM_CU; c++)
        breq[c] = cu_req[c] && (cu_bank[c] == BANK_W'(b)) && !bank_wr[b];
    end

    oparb_rr #(.N(NUM_CU)) i_rr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (breq),
      .adv_i   (bvalid),
      .gnt_o   (bank_gnt[b]),
      .idx_o   (bidx),
      .valid_o (bvalid)
    );

    oparb_bank #(.DEPTH(ROWS), .DATA_W(DATA_W)) i_bank (
      .clk_i   (clk_i),
      .we_i    (bank_wr[b]),
      .waddr_i (wb_row),
      .wdata_i (wb_data_i),
      .raddr_i (cu_row[bidx]),
      .rdata_o (bank_rdata[b])
    );
  end

  always_comb begin
    for (int unsigned c = 0; c < NUM_CU; c++) begin
      cu_gnt[c]   = bank_gnt[cu_bank[c]][c];
      cu_gdata[c] = bank_rdata[cu_bank[c]];
    end
  end

  oparb_rr #(.N(NUM_CU)) i_disp_rr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (cu_ready_o),
    .adv_i   (disp_ready_i),
    .gnt_o   (disp_gnt),
    .idx_o   (disp_cu_o),
    .valid_o (disp_valid_o)
  );

  assign disp_warp_o = cu_warp[disp_cu_o];
  assign disp_src_o  = cu_src[disp_cu_o];
endmodule

// File: rtl/oparb_checker.sv
module oparb_checker #(
  parameter int unsigned NUM_CU    = 8,
  parameter int unsigned NUM_BANKS = 32,
  parameter int unsigned CU_W      = 3
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             alloc_valid_i,
  input logic [CU_W-1:0]                  alloc_cu_i,
  input logic [1:0]                       alloc_nsrc_i,
  input logic [NUM_CU-1:0]                cu_free_o,
  input logic [NUM_CU-1:0]                cu_ready_o,
  input logic                             disp_valid_o,
  input logic                             disp_ready_i,
  input logic [CU_W-1:0]                  disp_cu_o,
  input logic [NUM_BANKS-1:0][NUM_CU-1:0] bank_gnt,
  input logic [NUM_BANKS-1:0]             bank_wr
);
  logic [NUM_CU-1:0][NUM_BANKS-1:0] cu_col;

  always_comb begin
    for (int unsigned c = 0; c < NUM_CU; c++)
      for (int unsigned b = 0; b < NUM_BANKS; b++) cu_col[c][b] = bank_gnt[b][c];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    AST_BANK_ONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(bank_gnt[b])); // R2
    AST_WB_OWNS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_wr[b] |-> (bank_gnt[b] == '0)); // R4
  end

  for (genvar c = 0; c < NUM_CU; c++) begin : g_cu_chk
    AST_CU_ONE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(cu_col[c])); // R3
    AST_READY_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cu_ready_o[c] && !(disp_valid_o && disp_ready_i && disp_cu_o == CU_W'(c))
      |=> cu_ready_o[c]); // R10
    AST_BUSY_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alloc_valid_i && alloc_cu_i == CU_W'(c) && !cu_free_o[c]
      && !(disp_valid_o && disp_ready_i && disp_cu_o == CU_W'(c))
      |=> !cu_free_o[c]); // R9
  end

  AST_DISP_ONLY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> cu_ready_o[disp_cu_o]); // R6
  AST_ZERO_SRC_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_i && cu_free_o[alloc_cu_i] && alloc_nsrc_i == 2'd0
    |=> cu_ready_o[$past(alloc_cu_i)]); // R8
  AST_FREE_AFTER_DISP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && disp_ready_i |=> cu_free_o[$past(disp_cu_o)]); // R10
endmodule

bind operand_bank_arbiter oparb_checker #(
  .NUM_CU(NUM_CU), .NUM_BANKS(NUM_BANKS), .CU_W(CU_W)
) i_oparb_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .alloc_valid_i (alloc_valid_i),
  .alloc_cu_i    (alloc_cu_i),
  .alloc_nsrc_i  (alloc_nsrc_i),
  .cu_free_o     (cu_free_o),
  .cu_ready_o    (cu_ready_o),
  .disp_valid_o  (disp_valid_o),
  .disp_ready_i  (disp_ready_i),
  .disp_cu_o     (disp_cu_o),
  .bank_gnt      (bank_gnt),
  .bank_wr       (bank_wr)
);

// File: tb/test_operand_bank_arbiter.sv
`timescale 1ns/1ps
module test_operand_bank_arbiter;
  localparam int NB = 4, NW = 4, NR = 8, NC = 3, DW = 16;
  localparam int WW = 2, RW = 3, CW = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic alloc_valid_i = 1'b0;
  logic [CW-1:0] alloc_cu_i = '0;
  logic [WW-1:0] alloc_warp_i = '0;
  logic [1:0] alloc_nsrc_i = '0;
  logic [3*RW-1:0] alloc_regs_i = '0;
  logic wb_valid_i = 1'b0;
  logic [WW-1:0] wb_warp_i = '0;
  logic [RW-1:0] wb_reg_i = '0;
  logic [DW-1:0] wb_data_i = '0;
  logic [NC-1:0] cu_free_o, cu_ready_o;
  logic disp_valid_o, disp_ready_i = 1'b0;
  logic [CW-1:0] disp_cu_o;
  logic [WW-1:0] disp_warp_o;
  logic [3*DW-1:0] disp_src_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  int rf [NW][NR];
  int exp_warp [NC];
  int exp_src [NC][3];

  always #2 clk_i = ~clk_i;

  operand_bank_arbiter #(.NUM_BANKS(NB), .NUM_WARPS(NW), .NUM_REGS(NR), .NUM_CU(NC), .DATA_W(DW))
  i_operand_bank_arbiter (.*);

  task automatic step(); @(negedge clk_i); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wb(input int w, input int r, input int d);
    wb_valid_i = 1'b1; wb_warp_i = WW'(w); wb_reg_i = RW'(r); wb_data_i = DW'(d);
    rf[w][r] = d;
    step();
    wb_valid_i = 1'b0;
  endtask

  task automatic do_alloc(input int cu, input int w, input int n, input int r0, input int r1,
                          input int r2, input bit rec);
    int rr [3];
    rr[0] = r0; rr[1] = r1; rr[2] = r2;
    alloc_valid_i = 1'b1; alloc_cu_i = CW'(cu); alloc_warp_i = WW'(w); alloc_nsrc_i = 2'(n);
    alloc_regs_i = {RW'(r2), RW'(r1), RW'(r0)};
    if (rec) begin
      exp_warp[cu] = w;
      for (int k = 0; k < 3; k++) exp_src[cu][k] = (k < n) ? rf[w][rr[k]] : 0;
    end
    step();
    alloc_valid_i = 1'b0;
  endtask

  // dispatch everything pending, checking warp and slot data (R6 layout, R1 storage)
  task automatic drain();
    disp_ready_i = 1'b1;
    for (int i = 0; i < 30; i++) begin
      if (disp_valid_o) begin
        chk(int'(disp_warp_o) == exp_warp[disp_cu_o], "R6 warp", int'(disp_warp_o), exp_warp[disp_cu_o]);
        for (int k = 0; k < 3; k++)
          chk(int'(disp_src_o[k*DW +: DW]) == exp_src[disp_cu_o][k], "R6/R1 slot data",
              int'(disp_src_o[k*DW +: DW]), exp_src[disp_cu_o][k]);
      end else if (&cu_free_o) break;
      step();
    end
    disp_ready_i = 1'b0;
    chk(&cu_free_o, "R10 drained", int'(cu_free_o), (1 << NC) - 1);
  endtask

  initial begin
    repeat (3) step();
    chk(&cu_free_o && cu_ready_o == '0 && !disp_valid_o, "R10 reset", int'(cu_free_o), (1 << NC) - 1);
    rst_ni = 1'b1;
    step();

    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++) wb(w, r, 'hA000 + w * 256 + r * 16 + 5);

    // R1: every (warp, reg) holds its own value
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++) begin
        do_alloc(0, w, 1, r, 0, 0, 1'b1);
        step();
        chk(cu_ready_o[0], "R1 ready", int'(cu_ready_o[0]), 1);
        drain();
      end

    // R6: slot layout for 1..3 sources, unused slots zero
    for (int n = 1; n <= 3; n++)
      for (int w = 0; w < NW; w++) begin
        do_alloc(0, w, n, w, (w + 3) % NR, (w + 6) % NR, 1'b1);
        repeat (n) step();
        drain();
      end

    // R3 / R8: k sources ready in cycle k+1, not earlier
    for (int n = 0; n <= 3; n++) begin
      do_alloc(1, 2, n, 1, 2, 3, 1'b1);
      if (n == 0) chk(cu_ready_o[1], "R8 zero-source ready", int'(cu_ready_o[1]), 1);
      else begin
        repeat (n - 1) step();
        chk(!cu_ready_o[1], "R3 early", int'(cu_ready_o[1]), 0);
        step();
        chk(cu_ready_o[1], "R3 on time", int'(cu_ready_o[1]), 1);
      end
      drain();
    end

    // R2: bank conflict sweep
    for (int w0 = 0; w0 < NW; w0++)
      for (int r0 = 0; r0 < 4; r0++)
        for (int w1 = 0; w1 < NW; w1++)
          for (int r1 = 0; r1 < 4; r1++) begin
            int conflict;
            conflict = ((w0 + r0) % NB) == ((w1 + r1) % NB);
            do_alloc(0, w0, 2, r0, r0, 0, 1'b1);
            do_alloc(1, w1, 1, r1, 0, 0, 1'b1);
            step();
            chk($countones(cu_ready_o) == (conflict ? 1 : 2), "R2 cycle 3",
                $countones(cu_ready_o), conflict ? 1 : 2);
            step();
            chk($countones(cu_ready_o) == 2, "R2 cycle 4", $countones(cu_ready_o), 2);
            drain();
          end

    // R11: alternating grants on one bank
    do_alloc(0, 0, 3, 0, 4, 0, 1'b1);
    do_alloc(1, 1, 3, 3, 7, 3, 1'b1);
    repeat (3) step();
    chk($countones(cu_ready_o) == 0, "R11 cycle 5", $countones(cu_ready_o), 0);
    step();
    chk($countones(cu_ready_o) == 1, "R11 cycle 6", $countones(cu_ready_o), 1);
    step();
    chk($countones(cu_ready_o) == 2, "R11 cycle 7", $countones(cu_ready_o), 2);
    drain();

    // R4 / R5: writebacks block the read, new value returned
    do_alloc(0, 0, 1, 0, 0, 0, 1'b0);
    wb(0, 0, 'h5A5A);
    wb(1, 3, 'h1234);
    exp_warp[0] = 0; exp_src[0][0] = 'h5A5A; exp_src[0][1] = 0; exp_src[0][2] = 0;
    chk(!cu_ready_o[0], "R4 blocked", int'(cu_ready_o[0]), 0);
    step();
    chk(cu_ready_o[0], "R4 after writes", int'(cu_ready_o[0]), 1);
    chk(int'(disp_src_o[DW-1:0]) == 'h5A5A || disp_cu_o != 0, "R5 new value",
        int'(disp_src_o[DW-1:0]), 'h5A5A);
    drain();

    // R9: allocation into busy collector ignored
    do_alloc(0, 1, 2, 2, 3, 0, 1'b1);
    do_alloc(0, 2, 0, 5, 5, 5, 1'b0);
    chk(!cu_free_o[0], "R9 still busy", int'(cu_free_o[0]), 0);
    step();
    drain();

    // R10: offer held, freed after handshake
    do_alloc(2, 3, 1, 5, 0, 0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(disp_valid_o && disp_cu_o == 2, "R10 hold", int'(disp_cu_o), 2);
    end
    disp_ready_i = 1'b1;
    chk(int'(disp_src_o[DW-1:0]) == rf[3][5], "R10 data", int'(disp_src_o[DW-1:0]), rf[3][5]);
    step();
    disp_ready_i = 1'b0;
    chk(cu_free_o[2] && !disp_valid_o, "R10 freed", int'(cu_free_o[2]), 1);

    // R7: round-robin dispatch order
    do_alloc(1, 0, 0, 0, 0, 0, 1'b1);
    drain();
    do_alloc(0, 0, 0, 0, 0, 0, 1'b1);
    do_alloc(1, 1, 0, 0, 0, 0, 1'b1);
    do_alloc(2, 2, 0, 0, 0, 0, 1'b1);
    disp_ready_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      int e;
      e = (i == 0) ? 2 : i - 1;
      chk(disp_valid_o && int'(disp_cu_o) == e, "R7 order", int'(disp_cu_o), e);
      step();
    end
    disp_ready_i = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule